// File: doc/BRIEF.md
# Accumulator Instruction Sequencer

This block is the control core of a small 16-bit processor built around one accumulator and a 4096-word memory of 16-bit words. A single sequence counter steps through numbered timing states, one clock each. The first three states fetch and decode an instruction. The fourth resolves an indirect operand address. The later states carry out the memory-reference operations: logical AND, add with carry, load, store, branch, call with return-address save, and increment-and-skip-if-zero. When an instruction has finished, the counter returns to state zero.

An instruction word holds an indirect flag in bit 15, an operation code in bits 14:12 and an operand address in bits 11:0. Operation code 7 is not executed here. The sequencer raises a request to a separate execution unit and holds in timing state 3 until that unit answers. The answer says whether to skip the next instruction and whether to stop. A run flip-flop gates all sequencing. A halt answer from the execution unit clears it, and a go pulse sets it again.

Memory is synchronous with one cycle of read latency. The sequencer presents the address that the address register is about to take, so the read data arrives in the next timing state.

Top module: `accum_sequencer`

## Requirements
- R1: Reset clears PC, AR, IR, DR, AC and E, sets the sequence counter to 0 and the run flip-flop to 1, so the first fetch reads address 0. No memory write happens in that first state.
- R2: Fetch takes states 0 to 2. An instruction word carries the indirect flag in bit 15, the opcode in bits 14:12 and the operand address in bits 11:0. PC advances by one per fetched word.
- R3: For opcodes 0 to 6 with the indirect flag set, the effective address is bits 11:0 of the word stored at the operand address. With the flag clear, the effective address is the operand address itself.
- R4: Opcode 0 gives AC = AC AND M[ea]. Opcode 1 gives {E, AC} = AC + M[ea], with the carry-out landing in E. Opcode 2 gives AC = M[ea]. E changes only on opcode 1.
- R5: Opcode 3 writes AC to M[ea], and at most one memory write source is active in any cycle. Opcode 4 sets PC = ea.
- R6: Opcode 5 writes the return address (the PC after fetch, zero-extended) to M[ea] and continues execution at ea + 1.
- R7: Opcode 6 writes M[ea] + 1 back to M[ea]. When the written value is 0, the next instruction is skipped (PC advances by one more).
- R8: Opcode 7 raises xReq in state 3 with xOp = {indirect flag, bits 11:0}. xReq holds with no other progress until xDone is 1. On that cycle PC is incremented once more if xSkip is 1, and the run flip-flop clears if xHalt is 1.
- R9: While halted, the sequence counter, PC and AC stay unchanged and no memory write occurs. A goReq pulse resumes with the instruction after the halting one.
- R10: An instruction takes this many cycles: AND, ADD, LDA and BSA take 6; STA and BUN take 5; ISZ takes 7; opcode 7 takes 4 plus the cycles spent waiting for xDone. The indirect flag does not change these counts, and the counter never goes past state 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| goReq | input | 1 | Sets the run flip-flop |
| runOut | output | 1 | Run flip-flop state |
| memAddr | output | 12 | Memory address (read or write) |
| memWdata | output | 16 | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRdata | input | 16 | Registered read data, valid one cycle after the address |
| xReq | output | 1 | Request to the register/I/O execution unit |
| xOp | output | 13 | Indirect flag and low 12 bits of the instruction |
| xDone | input | 1 | Execution unit finished |
| xSkip | input | 1 | Skip the next instruction |
| xHalt | input | 1 | Clear the run flip-flop |
| pcOut | output | 12 | Program counter |
| acOut | output | 16 | Accumulator |
| eOut | output | 1 | Carry flag E |

## Verification
The hardest case to reach from the ports is an increment-and-skip whose result wraps to zero exactly while other operations share memory with it, especially when the operand arrives through an indirect pointer and the skip lands on a halt. Random programs draw data words biased toward 0xFFFF and 0. They mix direct and indirect accesses through a pointer table, and they end with two halts, so a skip in the last position is absorbed. Each program also runs with a random response delay from the execution unit, which exercises the wait in state 3. A directed program closes the loop (count up to zero, branch back) and makes a call with an indirect return. It then halts, idles, and resumes with a go pulse.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 12;
  localparam int OP_W   = 3;
  localparam int SC_W   = 3;

  typedef struct packed {
    logic arFromPc;
    logic arFromIr;
    logic arFromMem;
    logic arInc;
    logic pcInc;
    logic pcFromAr;
    logic irLoad;
    logic indLoad;
    logic drFromMem;
    logic drInc;
    logic acAnd;
    logic acAdd;
    logic acLoad;
    logic wrAc;
    logic wrPc;
    logic wrDr;
  } seqCtl_t;
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqCtl_t       ctl,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memWe,
  output logic [OP_W-1:0] opcode,
  output logic          indFlag,
  output logic [AW:0]   xOp,
  output logic          drZero,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ac,
  output logic          e
);
  localparam int PAD_W = DW - AW;

  logic [AW-1:0] ar, arNext;
  logic [DW-1:0] ir, dr;
  logic [DW:0]   sum;

  always_comb begin
    arNext = ar;
    if (ctl.arFromPc)       arNext = pc;
    else if (ctl.arFromIr)  arNext = ir[AW-1:0];
    else if (ctl.arFromMem) arNext = memRdata[AW-1:0];
    else if (ctl.arInc)     arNext = ar + 1'b1;
  end

  assign memWe   = ctl.wrAc | ctl.wrPc | ctl.wrDr;
  assign memAddr = memWe ? ar : arNext;

  always_comb begin
    memWdata = dr;
    if (ctl.wrAc)      memWdata = ac;
    else if (ctl.wrPc) memWdata = {{PAD_W{1'b0}}, pc};
  end

  assign sum    = {1'b0, ac} + {1'b0, dr};
  assign opcode = ir[DW-2 -: OP_W];
  assign xOp    = {indFlag, ir[AW-1:0]};
  assign drZero = (dr == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ar <= '0; pc <= '0; ir <= '0; dr <= '0;
      ac <= '0; e <= 1'b0; indFlag <= 1'b0;
    end else begin
      ar <= arNext;
      if (ctl.pcFromAr)   pc <= ar;
      else if (ctl.pcInc) pc <= pc + 1'b1;
      if (ctl.irLoad)  ir <= memRdata;
      if (ctl.indLoad) indFlag <= ir[DW-1];
      if (ctl.drFromMem)  dr <= memRdata;
      else if (ctl.drInc) dr <= dr + 1'b1;
      if (ctl.acAnd)       ac <= ac & dr;
      else if (ctl.acLoad) ac <= dr;
      else if (ctl.acAdd) begin
        ac <= sum[DW-1:0];
        e  <= sum[DW];
      end
    end
  end

  // R5: never two write sources at once
  assert_one_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrAc, ctl.wrPc, ctl.wrDr}));

  // R7: writing back a zero count always skips
  assert_isz_skip_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrDr && dr == '0) |=> (pc == $past(pc) + 1'b1));

  // R6: the return-address store moves AR one word on
  assert_bsa_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrPc |=> (ar == $past(ar) + 1'b1));
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
#(
  parameter int NUM_T = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            goReq,
  input  logic [OP_W-1:0] opcode,
  input  logic            indFlag,
  input  logic            drZero,
  input  logic            xDone,
  input  logic            xSkip,
  input  logic            xHalt,
  output seqCtl_t         ctl,
  output logic            xReq,
  output logic            run
);
  localparam int NUM_OP = 1 << OP_W;

  logic [SC_W-1:0]   sc;
  logic [NUM_T-1:0]  tState;
  logic [NUM_OP-1:0] opDec;
  logic adv, clr, haltNow;

  for (genvar g = 0; g < NUM_T; g++) begin : gTime
    assign tState[g] = (sc == SC_W'(g));
  end
  for (genvar g = 0; g < NUM_OP; g++) begin : gOp
    assign opDec[g] = (opcode == OP_W'(g));
  end

  always_comb begin
    ctl = '0; adv = 1'b0; clr = 1'b0; xReq = 1'b0; haltNow = 1'b0;
    if (run) begin
      if (tState[0]) begin ctl.arFromPc = 1'b1; adv = 1'b1; end
      if (tState[1]) begin ctl.irLoad = 1'b1; ctl.pcInc = 1'b1; adv = 1'b1; end
      if (tState[2]) begin ctl.arFromIr = 1'b1; ctl.indLoad = 1'b1; adv = 1'b1; end
      if (tState[3]) begin
        if (opDec[7]) begin
          xReq = 1'b1;
          if (xDone) begin
            ctl.pcInc = xSkip; haltNow = xHalt; clr = 1'b1;
          end
        end else begin
          ctl.arFromMem = indFlag; adv = 1'b1;
        end
      end
      if (tState[4]) begin
        if (opDec[0] | opDec[1] | opDec[2] | opDec[6]) begin ctl.drFromMem = 1'b1; adv = 1'b1; end
        if (opDec[3]) begin ctl.wrAc = 1'b1; clr = 1'b1; end
        if (opDec[4]) begin ctl.pcFromAr = 1'b1; clr = 1'b1; end
        if (opDec[5]) begin ctl.wrPc = 1'b1; ctl.arInc = 1'b1; adv = 1'b1; end
      end
      if (tState[5]) begin
        if (opDec[0]) begin ctl.acAnd = 1'b1; clr = 1'b1; end
        if (opDec[1]) begin ctl.acAdd = 1'b1; clr = 1'b1; end
        if (opDec[2]) begin ctl.acLoad = 1'b1; clr = 1'b1; end
        if (opDec[5]) begin ctl.pcFromAr = 1'b1; clr = 1'b1; end
        if (opDec[6]) begin ctl.drInc = 1'b1; adv = 1'b1; end
      end
      if (tState[6]) begin
        ctl.wrDr = 1'b1; ctl.pcInc = drZero; clr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sc  <= '0;
      run <= 1'b1;
    end else begin
      if (clr)      sc <= '0;
      else if (adv) sc <= sc + 1'b1;
      if (goReq)        run <= 1'b1;
      else if (haltNow) run <= 1'b0;
    end
  end

  // R10: counter stays inside the seven timing states
  assert_sc_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    sc <= SC_W'(NUM_T - 1));

  // R9: halted sequencer does not move
  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !goReq) |=> $stable(sc));

  // R8: an unanswered request keeps waiting in the same state
  assert_xwait_R8: assert property (@(posedge clk) disable iff (!rstN)
    (xReq && !xDone) |=> (xReq && $stable(sc)));

  // R2: every instruction starts by copying PC to AR
  assert_fetch_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (run && sc == '0) |-> ctl.arFromPc);
endmodule

// File: rtl/accum_sequencer.sv
module accum_sequencer
  import seq_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          goReq,
  output logic          runOut,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memWe,
  input  logic [DW-1:0] memRdata,
  output logic          xReq,
  output logic [AW:0]   xOp,
  input  logic          xDone,
  input  logic          xSkip,
  input  logic          xHalt,
  output logic [AW-1:0] pcOut,
  output logic [DW-1:0] acOut,
  output logic          eOut
);
  seqCtl_t         ctl;
  logic [OP_W-1:0] opcode;
  logic            indFlag, drZero;

  seq_control u_ctrl (
    .clk(clk), .rstN(rstN), .goReq(goReq), .opcode(opcode), .indFlag(indFlag),
    .drZero(drZero), .xDone(xDone), .xSkip(xSkip), .xHalt(xHalt),
    .ctl(ctl), .xReq(xReq), .run(runOut)
  );

  seq_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .opcode(opcode), .indFlag(indFlag), .xOp(xOp), .drZero(drZero),
    .pc(pcOut), .ac(acOut), .e(eOut)
  );
endmodule

// File: tb/sim_accum_sequencer.sv
module sim_accum_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NPROG = 20;
  localparam int PLEN = 12;
  localparam int RUN_LIMIT = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic goReq = 1'b0;
  logic runOut, memWe, xReq, eOut;
  logic xDone = 1'b0, xSkip = 1'b0, xHalt = 1'b0;
  logic [11:0] memAddr, pcOut;
  logic [15:0] memWdata, memRdata, acOut;
  logic [12:0] xOp, lastOp;
  logic loadEn = 1'b0;
  logic [11:0] loadAddr = '0;
  logic [15:0] loadData = '0;
  logic [15:0] mem [4096];
  logic [15:0] refMem [4096];
  int nTests = 0, nFail = 0, execDelay = 0, waitCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accum_sequencer u0 (
    .clk(clk), .rstN(rstN), .goReq(goReq), .runOut(runOut),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata),
    .xReq(xReq), .xOp(xOp), .xDone(xDone), .xSkip(xSkip), .xHalt(xHalt),
    .pcOut(pcOut), .acOut(acOut), .eOut(eOut)
  );

  always @(posedge clk) begin
    if (loadEn) mem[loadAddr] <= loadData;
    else if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  // execution unit model: bit0 halts, bit2 skips on AC==0, bit1 skips on E==0
  always @(negedge clk) begin
    if (!xReq) begin
      xDone = 1'b0; xSkip = 1'b0; xHalt = 1'b0; waitCnt = 0;
    end else if (!xDone) begin
      if (waitCnt >= execDelay) begin
        xDone = 1'b1;
        xHalt = !xOp[12] && xOp[0];
        xSkip = !xOp[12] && ((xOp[2] && acOut == 16'h0) || (xOp[1] && !eOut));
        lastOp = xOp;
      end else waitCnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic putWord(input logic [11:0] a, input logic [15:0] d);
    loadEn = 1'b1; loadAddr = a; loadData = d; refMem[a] = d;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic refRun(input int dly, output logic [15:0] rAc, output logic rE,
                        output logic [11:0] rPc, output int rCyc);
    logic [15:0] w; logic [11:0] a; logic [16:0] s; bit go;
    rAc = '0; rE = 1'b0; rPc = '0; rCyc = 0; go = 1'b1;
    for (int step = 0; step < 300 && go; step++) begin
      w = refMem[rPc]; rPc = rPc + 1'b1; a = w[11:0];
      if (w[14:12] == 3'd7) begin
        rCyc += 4 + dly;
        if (!w[15]) begin
          if (w[0]) go = 1'b0;
          if ((w[2] && rAc == 16'h0) || (w[1] && !rE)) rPc = rPc + 1'b1;
        end
      end else begin
        if (w[15]) a = refMem[a][11:0];
        case (w[14:12])
          3'd0: begin rAc = rAc & refMem[a]; rCyc += 6; end
          3'd1: begin s = {1'b0, rAc} + {1'b0, refMem[a]}; rAc = s[15:0]; rE = s[16]; rCyc += 6; end
          3'd2: begin rAc = refMem[a]; rCyc += 6; end
          3'd3: begin refMem[a] = rAc; rCyc += 5; end
          3'd4: begin rPc = a; rCyc += 5; end
          3'd5: begin refMem[a] = {4'h0, rPc}; rPc = a + 1'b1; rCyc += 6; end
          default: begin
            refMem[a] = refMem[a] + 1'b1;
            if (refMem[a] == 16'h0) rPc = rPc + 1'b1;
            rCyc += 7;
          end
        endcase
      end
    end
  endtask

  task automatic runUntilHalt(output int cyc);
    cyc = 0;
    while (runOut && cyc < RUN_LIMIT) begin
      cyc++;
      @(negedge clk);
    end
    if (cyc >= RUN_LIMIT) chk(1'b0, "R10 run timeout", cyc, RUN_LIMIT);
  endtask

  task automatic releaseReset();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [15:0] eAc; logic eE; logic [11:0] ePc, pcHold; int eCyc, cyc, bad;
    logic [15:0] v;
    bit wrote;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) begin mem[i] = '0; refMem[i] = '0; end
    repeat (2) @(negedge clk);

    // ---- directed program: call, indirect load, ISZ loop, store, halt, resume
    execDelay = 3;
    putWord(12'h000, 16'h5030); // BSA 0x30
    putWord(12'h001, 16'hA021); // LDA I 0x21
    putWord(12'h002, 16'h6023); // ISZ 0x23
    putWord(12'h003, 16'h4002); // BUN 0x02
    putWord(12'h004, 16'h3024); // STA 0x24
    putWord(12'h005, 16'h7001); // halt
    putWord(12'h006, 16'h2025); // LDA 0x25
    putWord(12'h007, 16'h7001); // halt
    putWord(12'h031, 16'h1026); // ADD 0x26
    putWord(12'h032, 16'hC030); // BUN I 0x30
    putWord(12'h021, 16'h0022);
    putWord(12'h022, 16'h1234);
    putWord(12'h023, 16'hFFFD);
    putWord(12'h025, 16'hBEEF);
    putWord(12'h026, 16'h0001);
    refRun(execDelay, eAc, eE, ePc, eCyc);
    releaseReset();
    runUntilHalt(cyc);
    chk(mem[12'h030] == 16'h0001, "R6 return address stored", mem[12'h030], 16'h0001);
    chk(mem[12'h023] == 16'h0000, "R7 ISZ count reached zero", mem[12'h023], 16'h0000);
    chk(mem[12'h024] == 16'h1234, "R5 STA after skip / R3 indirect load", mem[12'h024], 16'h1234);
    chk(acOut == 16'h1234, "R3 AC from indirect LDA", acOut, 16'h1234);
    chk(pcOut == 12'h006, "R8 PC after halt", pcOut, 12'h006);
    chk(cyc == eCyc, "R10 directed cycle count", cyc, eCyc);
    chk(lastOp == 13'h0001, "R8 xOp carries I and low bits", lastOp, 13'h0001);
    // R9: halted, nothing moves
    pcHold = pcOut; wrote = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (memWe) wrote = 1'b1;
    end
    chk(!wrote && pcOut == pcHold && acOut == 16'h1234 && !runOut, "R9 frozen while halted",
        {wrote, pcOut}, {1'b0, pcHold});
    goReq = 1'b1; @(negedge clk); goReq = 1'b0;
    runUntilHalt(cyc);
    chk(acOut == 16'hBEEF && pcOut == 12'h008, "R9 resume after goReq", {acOut, 4'h0, pcOut},
        {16'hBEEF, 4'h0, 12'h008});

    // ---- reset state
    rstN = 1'b0;
    @(negedge clk);
    chk(pcOut == 0 && acOut == 0 && !eOut && runOut, "R1 reset values",
        {acOut, eOut, runOut, pcOut}, {16'h0, 1'b0, 1'b1, 12'h0});
    for (int i = 0; i < 8; i++) putWord(12'(i), 16'h7001);
    releaseReset();
    chk(memAddr == 12'h000 && !memWe, "R1 first fetch from address 0", {memWe, memAddr}, 13'h0);
    runUntilHalt(cyc);
    chk(pcOut == 12'h001 && cyc == 4 + execDelay, "R2 single-word fetch", {pcOut, 8'(cyc)},
        {12'h001, 8'(4 + execDelay)});

    // ---- random programs
    for (int p = 0; p < NPROG; p++) begin
      rstN = 1'b0;
      execDelay = $urandom_range(0, 3);
      @(negedge clk);
      for (int d = 0; d < 16; d++) begin
        case ($urandom_range(0, 7))
          0, 1:    v = 16'hFFFF;
          2:       v = 16'h0000;
          3:       v = 16'hFFFE;
          default: v = 16'($urandom);
        endcase
        putWord(12'h100 + 12'(d), v);
        putWord(12'h110 + 12'(d), 16'h0100 + 16'($urandom_range(0, 15)));
      end
      for (int i = 0; i < PLEN; i++) begin
        int kind; logic ind; logic [2:0] op; logic [11:0] a;
        kind = $urandom_range(0, 11);
        ind = 1'($urandom_range(0, 1));
        a = ind ? 12'h110 + 12'($urandom_range(0, 15)) : 12'h100 + 12'($urandom_range(0, 15));
        case (kind)
          0, 1: op = 3'd0;
          2, 3: op = 3'd1;
          4, 5: op = 3'd2;
          6, 7: op = 3'd3;
          8, 9: op = 3'd6;
          default: op = 3'd7;
        endcase
        if (op == 3'd7) putWord(12'(i), (kind == 10) ? 16'h7004 : 16'h7002);
        else putWord(12'(i), {ind, op, a});
      end
      putWord(12'(PLEN), 16'h7001);
      putWord(12'(PLEN + 1), 16'h7001);
      refRun(execDelay, eAc, eE, ePc, eCyc);
      releaseReset();
      runUntilHalt(cyc);
      chk(acOut == eAc, "R4 random AC", acOut, eAc);
      chk(eOut == eE, "R4 random E carry", eOut, eE);
      chk(pcOut == ePc, "R7 random PC incl. skips", pcOut, ePc);
      chk(cyc == eCyc, "R10 random cycle count", cyc, eCyc);
      bad = 0;
      for (int a = 12'h100; a < 12'h120; a++) if (mem[a] !== refMem[a]) bad++;
      chk(bad == 0, "R5 random memory contents", bad, 0);
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule